// File: doc/BRIEF.md
# Dual-Port Word Memory with Collision Busy and Mailbox Interrupts

This block is a synchronous word memory that two agents, called left and right, reach through two fully independent ports. In any clock cycle each port may read or write any word. Each port has an enable, a write strobe, a read-output enable, two byte-lane selects and an address. A write needs a rising clock edge to land. Read data is registered and appears one cycle after the request. The word width is a parameter, normally 16 or 18 bits, and the depth is a parameter.

When both ports address the same word in one cycle, a busy flag tells the losing port to retry, and that port's write is dropped. A strap input picks where busy comes from:
- As master, this block computes busy itself. The left port always wins.
- As slave, busy is taken from pins. This lets several copies that share an address bus form a wider word with one master arbitrating for all of them.

The two highest words also act as mailboxes. When the right port writes the top word, the left port's active-low interrupt is raised. When the left port writes the word below it, the right port's interrupt is raised. A read of its own mailbox word by the interrupted port releases the interrupt.

Each mailbox is a two-state machine:
- `MB_IDLE` moves to `MB_POSTED` on a set event.
- `MB_POSTED` returns to `MB_IDLE` on a clear event that has no set event in the same cycle. A set in that cycle keeps it posted.

Top module: `dpr_collide_top`

## Requirements
- R1: Both ports can read and write any word in the same cycle. A read request (enable and output enable high, write strobe low) returns the stored word on that port's read bus one cycle later.
- R2: Byte-lane select `lo_sel` gates bits [LO_W-1:0] and `hi_sel` gates bits [WORD_W-1:LO_W], where LO_W = WORD_W/2: bits 0–8 and 9–17 for 18-bit words, bits 0–7 and 8–15 for 16-bit words. A lane that is not selected keeps its old value.
- R3: With `is_master` high, `r_busy` is high in the same cycle in which both ports are enabled on the same address, and low otherwise. `l_busy` stays low.
- R4: With `is_master` low, `l_busy` and `r_busy` follow `l_busy_in` and `r_busy_in`. The busy-in of the other setting is ignored.
- R5: A port whose busy output is high does not write the memory. The other port's write to the same word lands. A suppressed write also posts no mailbox interrupt.
- R6: A port's read bus is all zeros in the cycle after any cycle without a read request on that port, for example when output enable is low or the port is writing.
- R7: If one port writes a word that the other port reads in the same cycle, the reader gets the old word. A read in the following cycle gets the new word.
- R8: A right-port write to address DEPTH-1 drives `l_int_n` low from the next cycle on. A left-port read of DEPTH-1 drives it high again the cycle after.
- R9: A left-port write to address DEPTH-2 drives `r_int_n` low from the next cycle on. A right-port read of DEPTH-2 drives it high again the cycle after.
- R10: After reset, both interrupt outputs are high and both read buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1: busy is computed here; 0: busy is taken from the busy-in pins |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left write strobe |
| l_oe | input | 1 | Left read-output enable |
| l_lo_sel | input | 1 | Left lower byte-lane select |
| l_hi_sel | input | 1 | Left upper byte-lane select |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | WORD_W | Left write data |
| l_rdata | output | WORD_W | Left registered read data |
| l_busy_in | input | 1 | Left busy from outside, used in slave mode |
| l_busy | output | 1 | Left busy flag |
| l_int_n | output | 1 | Left mailbox interrupt, active low |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right write strobe |
| r_oe | input | 1 | Right read-output enable |
| r_lo_sel | input | 1 | Right lower byte-lane select |
| r_hi_sel | input | 1 | Right upper byte-lane select |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | WORD_W | Right write data |
| r_rdata | output | WORD_W | Right registered read data |
| r_busy_in | input | 1 | Right busy from outside, used in slave mode |
| r_busy | output | 1 | Right busy flag |
| r_int_n | output | 1 | Right mailbox interrupt, active low |

## Verification
Busy is combinational, so the bench drives each cycle's inputs just after the falling edge and samples busy a moment later, before the next rising edge. Read data and both interrupts each pass through exactly one register, so they are sampled at the falling edge that follows the request's rising edge. That sample point is one cycle after the request, and it comes before any new stimulus is applied. The flow-through and suppression cases check the memory contents only through a later read, one further cycle on.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    typedef enum logic {
        MB_IDLE   = 1'b0,
        MB_POSTED = 1'b1
    } mb_state_e;

    typedef struct packed {
        logic rd;
        logic wr_lo;
        logic wr_hi;
    } port_req_t;
endpackage

// File: rtl/dpr_port_ctl.sv
module dpr_port_ctl
    import dpr_pkg::*;
(
    input  logic      en,
    input  logic      we,
    input  logic      oe,
    input  logic      lo_sel,
    input  logic      hi_sel,
    input  logic      busy,
    output port_req_t req
);
    logic wr_ok;

    always_comb begin
        wr_ok     = en && we && !busy;
        req.rd    = en && oe && !we;
        req.wr_lo = wr_ok && lo_sel;
        req.wr_hi = wr_ok && hi_sel;
    end
endmodule

// File: rtl/dpr_busy_arb.sv
module dpr_busy_arb #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              l_en,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_busy_in,
    input  logic              r_busy_in,
    output logic              l_busy,
    output logic              r_busy
);
    logic clash;

    always_comb begin
        clash = l_en && r_en && (l_addr == r_addr);
        if (is_master) begin
            l_busy = 1'b0;
            r_busy = clash;
        end else begin
            l_busy = l_busy_in;
            r_busy = r_busy_in;
        end
    end

    AST_LEFT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        is_master |-> !l_busy); // R3
endmodule

// File: rtl/dpr_mailbox.sv
module dpr_mailbox
    import dpr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic int_n
);
    mb_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MB_IDLE:   if (set_evt) state_d = MB_POSTED;
            MB_POSTED: if (clr_evt && !set_evt) state_d = MB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MB_IDLE;
        else        state_q <= state_d;
    end

    always_comb int_n = (state_q != MB_POSTED);

    AST_MB_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> !int_n); // R8
    AST_MB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> int_n); // R9
endmodule

// File: rtl/dpr_core_mem.sv
module dpr_core_mem
    import dpr_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_req_t         l_req,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [WORD_W-1:0] l_wdata,
    output logic [WORD_W-1:0] l_rdata,
    input  port_req_t         r_req,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [WORD_W-1:0] r_wdata,
    output logic [WORD_W-1:0] r_rdata
);
    localparam int LO_W = WORD_W / 2;

    logic [WORD_W-1:0] mem [DEPTH];

    // Right is written first so that a left write to the same lane wins.
    always_ff @(posedge clk) begin
        if (r_req.wr_lo) mem[r_addr][LO_W-1:0]      <= r_wdata[LO_W-1:0];
        if (r_req.wr_hi) mem[r_addr][WORD_W-1:LO_W] <= r_wdata[WORD_W-1:LO_W];
        if (l_req.wr_lo) mem[l_addr][LO_W-1:0]      <= l_wdata[LO_W-1:0];
        if (l_req.wr_hi) mem[l_addr][WORD_W-1:LO_W] <= l_wdata[WORD_W-1:LO_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_rdata <= '0;
            r_rdata <= '0;
        end else begin
            l_rdata <= l_req.rd ? mem[l_addr] : '0;
            r_rdata <= r_req.rd ? mem[r_addr] : '0;
        end
    end

    AST_L_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !l_req.rd |=> (l_rdata == '0)); // R6
    AST_R_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !r_req.rd |=> (r_rdata == '0)); // R6
endmodule

// File: rtl/dpr_collide_top.sv
module dpr_collide_top
    import dpr_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              l_en,
    input  logic              l_we,
    input  logic              l_oe,
    input  logic              l_lo_sel,
    input  logic              l_hi_sel,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [WORD_W-1:0] l_wdata,
    output logic [WORD_W-1:0] l_rdata,
    input  logic              l_busy_in,
    output logic              l_busy,
    output logic              l_int_n,
    input  logic              r_en,
    input  logic              r_we,
    input  logic              r_oe,
    input  logic              r_lo_sel,
    input  logic              r_hi_sel,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [WORD_W-1:0] r_wdata,
    output logic [WORD_W-1:0] r_rdata,
    input  logic              r_busy_in,
    output logic              r_busy,
    output logic              r_int_n
);
    localparam logic [ADDR_W-1:0] MB_TO_LEFT  = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] MB_TO_RIGHT = ADDR_W'(DEPTH - 2);

    port_req_t l_req, r_req;
    logic      l_mb_set, l_mb_clr, r_mb_set, r_mb_clr;

    dpr_busy_arb #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .is_master(is_master),
        .l_en(l_en), .r_en(r_en), .l_addr(l_addr), .r_addr(r_addr),
        .l_busy_in(l_busy_in), .r_busy_in(r_busy_in),
        .l_busy(l_busy), .r_busy(r_busy)
    );

    dpr_port_ctl u_lctl (
        .en(l_en), .we(l_we), .oe(l_oe), .lo_sel(l_lo_sel), .hi_sel(l_hi_sel),
        .busy(l_busy), .req(l_req)
    );

    dpr_port_ctl u_rctl (
        .en(r_en), .we(r_we), .oe(r_oe), .lo_sel(r_lo_sel), .hi_sel(r_hi_sel),
        .busy(r_busy), .req(r_req)
    );

    dpr_core_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .l_req(l_req), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_req(r_req), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    always_comb begin
        l_mb_set = (r_req.wr_lo || r_req.wr_hi) && (r_addr == MB_TO_LEFT);
        l_mb_clr = l_req.rd && (l_addr == MB_TO_LEFT);
        r_mb_set = (l_req.wr_lo || l_req.wr_hi) && (l_addr == MB_TO_RIGHT);
        r_mb_clr = r_req.rd && (r_addr == MB_TO_RIGHT);
    end

    dpr_mailbox u_mb_left (
        .clk(clk), .rst_n(rst_n), .set_evt(l_mb_set), .clr_evt(l_mb_clr), .int_n(l_int_n)
    );

    dpr_mailbox u_mb_right (
        .clk(clk), .rst_n(rst_n), .set_evt(r_mb_set), .clr_evt(r_mb_clr), .int_n(r_int_n)
    );

    AST_SAME_ADDR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && l_en && r_en && (l_addr == r_addr)) |-> r_busy); // R3
    AST_BUSY_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        r_busy |-> !(r_req.wr_lo || r_req.wr_hi)); // R5
    AST_RIGHT_MB_POST: assert property (@(posedge clk) disable iff (!rst_n)
        r_mb_set |=> !r_int_n); // R9
endmodule

// File: tb/dpr_collide_top_tb.sv
module dpr_collide_top_tb;
    localparam int W = 18;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic is_master = 1'b1;
    logic l_en = 0, l_we = 0, l_oe = 0, l_lo = 1, l_hi = 1, l_bin = 0;
    logic r_en = 0, r_we = 0, r_oe = 0, r_lo = 1, r_hi = 1, r_bin = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [W-1:0]  l_wd = '0, r_wd = '0;
    logic [W-1:0]  l_rd, r_rd;
    logic l_busy, r_busy, l_int_n, r_int_n;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dpr_collide_top u_dut (
        .clk(clk), .rst_n(rst_n), .is_master(is_master),
        .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_lo_sel(l_lo), .l_hi_sel(l_hi),
        .l_addr(l_addr), .l_wdata(l_wd), .l_rdata(l_rd),
        .l_busy_in(l_bin), .l_busy(l_busy), .l_int_n(l_int_n),
        .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_lo_sel(r_lo), .r_hi_sel(r_hi),
        .r_addr(r_addr), .r_wdata(r_wd), .r_rdata(r_rd),
        .r_busy_in(r_bin), .r_busy(r_busy), .r_int_n(r_int_n)
    );

    typedef struct packed {
        logic          le, lw, lo;
        logic [AW-1:0] la;
        logic [W-1:0]  lwd;
        logic          re, rw, ro;
        logic [AW-1:0] ra;
        logic [W-1:0]  rwd;
        logic [W-1:0]  exp_l, exp_r;
        logic          exp_rb;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{1,1,0, 8'h10, 18'h0AAAA, 1,1,0, 8'h20, 18'h15555, 18'h0,     18'h0,     1'b0}, // R1 writes
        '{1,0,1, 8'h20, 18'h0,     1,0,1, 8'h10, 18'h0,     18'h15555, 18'h0AAAA, 1'b0}, // R1 cross reads
        '{1,1,0, 8'h30, 18'h12345, 0,0,0, 8'h00, 18'h0,     18'h0,     18'h0,     1'b0},
        '{1,1,0, 8'h30, 18'h2ABCD, 1,0,1, 8'h30, 18'h0,     18'h0,     18'h12345, 1'b1}, // R7 old word
        '{0,0,0, 8'h00, 18'h0,     1,0,1, 8'h30, 18'h0,     18'h0,     18'h2ABCD, 1'b0}, // R7 new word
        '{1,1,0, 8'h40, 18'h11111, 1,1,0, 8'h40, 18'h22222, 18'h0,     18'h0,     1'b1}, // R5 clash
        '{1,0,1, 8'h40, 18'h0,     1,0,1, 8'h40, 18'h0,     18'h11111, 18'h11111, 1'b1}, // R5 left kept
        '{1,0,0, 8'h10, 18'h0,     1,0,1, 8'h20, 18'h0,     18'h0,     18'h15555, 1'b0}  // R6 oe low
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        l_en = 0; l_we = 0; l_oe = 0; l_lo = 1; l_hi = 1;
        r_en = 0; r_we = 0; r_oe = 0; r_lo = 1; r_hi = 1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 l_rdata", 32'(l_rd), 32'h0);
        chk("R10 r_rdata", 32'(r_rd), 32'h0);
        chk("R10 l_int_n", 32'(l_int_n), 32'h1);
        chk("R10 r_int_n", 32'(r_int_n), 32'h1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            l_en = VT[i].le; l_we = VT[i].lw; l_oe = VT[i].lo; l_addr = VT[i].la; l_wd = VT[i].lwd;
            r_en = VT[i].re; r_we = VT[i].rw; r_oe = VT[i].ro; r_addr = VT[i].ra; r_wd = VT[i].rwd;
            #1;
            chk("R3 r_busy", 32'(r_busy), 32'(VT[i].exp_rb));
            chk("R3 l_busy", 32'(l_busy), 32'h0);
            tick();
            chk("R1/R6/R7 l_rdata", 32'(l_rd), 32'(VT[i].exp_l));
            chk("R1/R5/R7 r_rdata", 32'(r_rd), 32'(VT[i].exp_r));
        end
        idle();

        // R2 byte lanes
        l_en = 1; l_we = 1; l_addr = 8'h50; l_wd = 18'h3FFFF; tick();
        l_lo = 1; l_hi = 0; l_wd = 18'h0; tick();
        l_we = 0; l_oe = 1; l_lo = 1; l_hi = 1; tick();
        chk("R2 lower lane only", 32'(l_rd), 32'h3FE00);
        l_we = 1; l_oe = 0; l_lo = 0; l_hi = 1; l_wd = 18'h0; tick();
        l_we = 0; l_oe = 1; l_hi = 1; l_lo = 1; tick();
        chk("R2 upper lane only", 32'(l_rd), 32'h0);
        idle();

        // R8 mailbox to left
        r_en = 1; r_we = 1; r_addr = 8'hFF; r_wd = 18'h00777; tick();
        idle();
        chk("R8 set", 32'(l_int_n), 32'h0);
        chk("R8 other side", 32'(r_int_n), 32'h1);
        l_en = 1; l_oe = 1; l_addr = 8'hFF; tick();
        idle();
        chk("R8 message data", 32'(l_rd), 32'h00777);
        chk("R8 cleared", 32'(l_int_n), 32'h1);

        // R9 mailbox to right
        l_en = 1; l_we = 1; l_addr = 8'hFE; l_wd = 18'h00123; tick();
        idle();
        chk("R9 set", 32'(r_int_n), 32'h0);
        r_en = 1; r_oe = 1; r_addr = 8'hFE; tick();
        idle();
        chk("R9 cleared", 32'(r_int_n), 32'h1);

        // R5 suppressed mailbox write posts nothing
        l_en = 1; l_oe = 1; l_addr = 8'hFF; r_en = 1; r_we = 1; r_addr = 8'hFF; r_wd = 18'h00999;
        #1;
        chk("R5 mailbox clash busy", 32'(r_busy), 32'h1);
        tick();
        idle();
        chk("R5 no interrupt", 32'(l_int_n), 32'h1);
        l_en = 1; l_oe = 1; l_addr = 8'hFF; tick();
        idle();
        chk("R5 mailbox word kept", 32'(l_rd), 32'h00777);

        // R4 slave mode
        l_en = 1; l_we = 1; l_addr = 8'h60; l_wd = 18'h00005; tick();
        idle();
        is_master = 0; l_bin = 1; r_bin = 0;
        l_en = 1; l_we = 1; l_addr = 8'h60; l_wd = 18'h00077;
        r_en = 1; r_we = 1; r_addr = 8'h61; r_wd = 18'h00042;
        #1;
        chk("R4 l_busy follows pin", 32'(l_busy), 32'h1);
        chk("R4 r_busy follows pin", 32'(r_busy), 32'h0);
        tick();
        idle();
        l_bin = 0;
        l_en = 1; l_oe = 1; l_addr = 8'h60; r_en = 1; r_oe = 1; r_addr = 8'h61; tick();
        idle();
        chk("R4/R5 slave left suppressed", 32'(l_rd), 32'h00005);
        chk("R4 slave right landed", 32'(r_rd), 32'h00042);
        r_bin = 1;
        r_en = 1; l_en = 1; l_addr = 8'h10; r_addr = 8'h10; #1;
        chk("R4 r_busy from pin in slave", 32'(r_busy), 32'h1);
        idle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule